// File: doc/BRIEF.md
# Real-Time Counter with Alarm

This block keeps a 32-bit running count of seconds for a system that needs wall-clock time or a wake-up alarm. Counting is driven by one of two event sources: every cycle of the bus clock, or each rising edge of a slow external clock that is synchronised into the bus clock domain. A programmable prescaler divides those source events down to a one-second tick. Each tick advances the counter and latches a periodic event.

Software controls the block through a small register window. It can gate the counter without losing its value, preset the count through a load register, program an alarm value, and mask or clear two interrupts. The alarm interrupt is raised when the counter enters equality with the alarm value. The periodic interrupt is raised on every prescaler tick. Each interrupt has a sticky status bit that software clears by writing 1 to it, and each interrupt output is gated by its own mask bit.

Register map (byte offsets): 0x00 control, 0x04 load, 0x08 alarm, 0x0C status, 0x10 count (read-only), 0x14 prescale. Any other offset reads as zero and ignores writes.

Top module: `rtc_alarm_top`

## Requirements
- R1: The control register at 0x00 holds four bits in little-endian data positions: counter enable at bit 7, source select at bit 6, alarm mask at bit 1 and periodic mask at bit 0. All other bits read as zero, and writes to them are ignored.
- R2: While the enable bit is 0 the counter keeps its value. When the bit is set again, counting resumes from the held value, and the prescaler phase is also kept.
- R3: With select at 0, every bus clock cycle is one source event. With select at 1, each rising edge of ext_clk is one source event, seen after a two-stage synchroniser, and the bus clock alone advances nothing.
- R4: While enabled, the counter advances by one for every PRESC+1 source events. PRESC is the prescale register at 0x14, which is PRESC_W bits wide and resets to PRESC_RESET.
- R5: The load register at 0x04 resets to zero and reads back what was written. Its value enters the counter at the next source event, whether or not the counter is enabled. A pending load takes priority over an increment at the same event.
- R6: Status bit 1 at 0x0C sets on the cycle after the counter enters equality with the alarm register at 0x08, whether it got there by counting or by a load. irq_alarm equals status bit 1 ANDed with the alarm mask.
- R7: If the counter stays at the alarm value after its status bit has been cleared, the alarm status is not set again.
- R8: Status bit 0 sets on each prescaler tick. irq_tick equals status bit 0 ANDed with the periodic mask, so no periodic interrupt appears while the mask is 0.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R10: After reset the control, load, alarm, status and count registers read zero, prescale reads PRESC_RESET, and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk | input | 1 | Slow external clock, asynchronous to clk |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_tick | output | 1 | Periodic interrupt |

## Verification
Register writes take effect at the clock edge where reg_we is sampled. Read data is combinational, so the bench reads it one time step after the falling edge that follows. A load reaches the count one edge after the write when the bus clock is the source. An alarm status bit appears one edge after the count becomes equal. An external edge is counted two to three bus cycles after it happens. The bench counts falling edges from each write to know exactly which edges have advanced the prescaler. It checks counts only at those edges, and it waits out the synchroniser delay before it samples anything that depends on ext_clk.

// File: rtl/rtc_pkg.sv
// Shared register offsets and bit positions for the real-time counter.
package rtc_pkg;
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_LOAD  = 'h04;
    localparam int OFS_ALARM = 'h08;
    localparam int OFS_STS   = 'h0C;
    localparam int OFS_COUNT = 'h10;
    localparam int OFS_PRESC = 'h14;

    // Control bits (little-endian data positions)
    localparam int CB_EN    = 7;
    localparam int CB_SEL   = 6;
    localparam int CB_AMASK = 1;
    localparam int CB_PMASK = 0;

    // Status bits
    localparam int SB_TICK  = 0;
    localparam int SB_ALARM = 1;
endpackage

// File: rtl/rtc_clk_src.sv
// Source-event generator. Synchronises the external slow clock into the
// bus clock domain, detects its rising edge, and chooses between that edge
// and a constant per-cycle event. Assumes ext_clk is much slower than clk.
module rtc_clk_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic sel_ext,
    output logic src_tick
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               ext_rise;

    // Shift the external clock through the synchroniser plus one edge stage
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], ext_clk};
    end

    // Rising edge seen on the synchronised signal
    assign ext_rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    // Choose the event source
    assign src_tick = sel_ext ? ext_rise : 1'b1;

    AST_EXT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise); // R3
endmodule

// File: rtl/rtc_prescaler.sv
// Divides source events down to a one-second tick. A tick falls on every
// (presc+1)-th source event while enabled; the phase is frozen while disabled.
module rtc_prescaler #(
    parameter int PRESC_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_tick,
    input  logic               en,
    input  logic [PRESC_W-1:0] presc,
    output logic               sec_tick
);
    logic [PRESC_W-1:0] pcnt_q;

    // Tick when the phase counter has reached the programmed limit
    assign sec_tick = en & src_tick & (pcnt_q >= presc);

    // Advance the phase counter on each enabled source event
    always_ff @(posedge clk) begin
        if (!rst_n)              pcnt_q <= '0;
        else if (en && src_tick) pcnt_q <= sec_tick ? '0 : pcnt_q + 1'b1;
    end

    AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(pcnt_q)); // R2
endmodule

// File: rtl/rtc_counter.sv
// The counter itself with load and alarm compare. A load request is held
// pending until the next source event, where it wins over the increment.
// The alarm event fires only on entry into equality with the alarm value.
module rtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick,
    input  logic             sec_tick,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] alarm_val,
    output logic [CNT_W-1:0] cnt,
    output logic             alarm_evt
);
    logic             load_pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic             match;
    logic             match_q;

    // Hold a load request until a source event consumes it
    always_ff @(posedge clk) begin
        if (!rst_n)        load_pend_q <= 1'b0;
        else if (load_req) load_pend_q <= 1'b1;
        else if (src_tick) load_pend_q <= 1'b0;
    end

    // Counter update: load first, then increment on tick
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (load_pend_q && src_tick) cnt_q <= load_val;
        else if (sec_tick)                cnt_q <= cnt_q + 1'b1;
    end

    // Remember last cycle's compare result; starts high so reset is silent
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b1;
        else        match_q <= match;
    end

    assign match     = (cnt_q == alarm_val);
    assign alarm_evt = match & ~match_q;
    assign cnt       = cnt_q;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_pend_q && src_tick) |=> (cnt_q == $past(load_val))); // R5
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !(load_pend_q && src_tick)) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/rtc_alarm_top.sv
// Real-time counter top: register window, status latching and interrupt
// gating around the source selector, prescaler and counter. Registers are
// written on a one-cycle reg_we strobe; reads are combinational.
module rtc_alarm_top #(
    parameter int ADDR_W      = 5,
    parameter int PRESC_W     = 16,
    parameter int PRESC_RESET = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_alarm,
    output logic              irq_tick
);
    import rtc_pkg::*;

    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFS_LOAD);
    localparam logic [ADDR_W-1:0] A_ALARM = ADDR_W'(OFS_ALARM);
    localparam logic [ADDR_W-1:0] A_STS   = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(OFS_PRESC);

    logic               en_q, sel_q, amask_q, pmask_q;
    logic [DATA_W-1:0]  load_q, alarm_q;
    logic [PRESC_W-1:0] presc_q;
    logic               sts_tick_q, sts_alarm_q;
    logic               src_tick, sec_tick, alarm_evt;
    logic [DATA_W-1:0]  cnt;
    logic               wr_ctrl, wr_load, wr_alarm, wr_sts, wr_presc;

    assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
    assign wr_load  = reg_we && (reg_addr == A_LOAD);
    assign wr_alarm = reg_we && (reg_addr == A_ALARM);
    assign wr_sts   = reg_we && (reg_addr == A_STS);
    assign wr_presc = reg_we && (reg_addr == A_PRESC);

    // Control, load, alarm and prescale registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            sel_q   <= 1'b0;
            amask_q <= 1'b0;
            pmask_q <= 1'b0;
            load_q  <= '0;
            alarm_q <= '0;
            presc_q <= PRESC_W'(PRESC_RESET);
        end else begin
            if (wr_ctrl) begin
                en_q    <= reg_wdata[CB_EN];
                sel_q   <= reg_wdata[CB_SEL];
                amask_q <= reg_wdata[CB_AMASK];
                pmask_q <= reg_wdata[CB_PMASK];
            end
            if (wr_load)  load_q  <= reg_wdata;
            if (wr_alarm) alarm_q <= reg_wdata;
            if (wr_presc) presc_q <= reg_wdata[PRESC_W-1:0];
        end
    end

    // Sticky status bits: a new event wins over a write-1 clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_tick_q  <= 1'b0;
            sts_alarm_q <= 1'b0;
        end else begin
            sts_tick_q  <= sec_tick  | (sts_tick_q  & ~(wr_sts & reg_wdata[SB_TICK]));
            sts_alarm_q <= alarm_evt | (sts_alarm_q & ~(wr_sts & reg_wdata[SB_ALARM]));
        end
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: begin
                reg_rdata[CB_EN]    = en_q;
                reg_rdata[CB_SEL]   = sel_q;
                reg_rdata[CB_AMASK] = amask_q;
                reg_rdata[CB_PMASK] = pmask_q;
            end
            A_LOAD:  reg_rdata = load_q;
            A_ALARM: reg_rdata = alarm_q;
            A_STS: begin
                reg_rdata[SB_TICK]  = sts_tick_q;
                reg_rdata[SB_ALARM] = sts_alarm_q;
            end
            A_COUNT: reg_rdata = cnt;
            A_PRESC: reg_rdata = DATA_W'(presc_q);
            default: reg_rdata = '0;
        endcase
    end

    assign irq_alarm = sts_alarm_q & amask_q;
    assign irq_tick  = sts_tick_q & pmask_q;

    rtc_clk_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_clk  (ext_clk),
        .sel_ext  (sel_q),
        .src_tick (src_tick)
    );

    rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .en       (en_q),
        .presc    (presc_q),
        .sec_tick (sec_tick)
    );

    rtc_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_tick  (src_tick),
        .sec_tick  (sec_tick),
        .load_req  (wr_load),
        .load_val  (load_q),
        .alarm_val (alarm_q),
        .cnt       (cnt),
        .alarm_evt (alarm_evt)
    );

    AST_ALARM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> sts_alarm_q); // R6
    AST_W1C_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && reg_wdata[SB_ALARM] && !alarm_evt) |=> !sts_alarm_q); // R9
    AST_TICK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> sts_tick_q); // R8
endmodule

// File: tb/rtc_alarm_top_tb.sv
// Self-checking bench: a register vector table, then directed tests.
module rtc_alarm_top_tb_top;
    localparam int ADDR_W = 5;
    localparam int PRESC_RESET = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ext_clk = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_we = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq_alarm, irq_tick;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #10 clk = ~clk; // 50 MHz

    rtc_alarm_top #(.ADDR_W(ADDR_W), .PRESC_RESET(PRESC_RESET)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_alarm(irq_alarm), .irq_tick(irq_tick)
    );

    // Table row: {we, addr[4:0], wdata[31:0], expected read[31:0]}
    localparam int NROW = 10;
    localparam logic [69:0] TBL [NROW] = '{
        {1'b1, 5'h00, 32'hFFFFFF7F, 32'h00000043}, // R1 only defined bits kept
        {1'b1, 5'h00, 32'h00000000, 32'h00000000}, // R1
        {1'b1, 5'h00, 32'h00000003, 32'h00000003}, // R1 masks
        {1'b1, 5'h00, 32'h00000000, 32'h00000000}, // R1
        {1'b1, 5'h08, 32'hDEADBEEF, 32'hDEADBEEF}, // R6 alarm register
        {1'b1, 5'h14, 32'h00012345, 32'h00002345}, // R4 prescale width
        {1'b1, 5'h14, 32'h00000003, 32'h00000003}, // R4
        {1'b1, 5'h04, 32'h00000064, 32'h00000064}, // R5 load readback
        {1'b0, 5'h10, 32'h00000000, 32'h00000064}, // R5 load reached count
        {1'b0, 5'h18, 32'h00000000, 32'h00000000}  // unmapped reads zero
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Starts at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        rd(5'h00, rv); chk("R10 ctrl", rv, 32'h0);
        rd(5'h04, rv); chk("R10 load", rv, 32'h0);
        rd(5'h08, rv); chk("R10 alarm", rv, 32'h0);
        rd(5'h0C, rv); chk("R10 status", rv, 32'h0);
        rd(5'h10, rv); chk("R10 count", rv, 32'h0);
        rd(5'h14, rv); chk("R10 prescale", rv, 32'(PRESC_RESET));
        chk("R10 irqs", {30'b0, irq_alarm, irq_tick}, 32'h0);

        // Vector table
        for (int r = 0; r < NROW; r++) begin
            if (TBL[r][69]) wr(TBL[r][68:64], TBL[r][63:32]);
            rd(TBL[r][68:64], rv);
            chk($sformatf("table row %0d", r), rv, TBL[r][31:0]);
            @(negedge clk);
        end

        // R4: prescale 3 on the bus clock, 40 events -> 10 increments
        wr(5'h00, 32'h80);
        wait_n(40);
        rd(5'h10, rv); chk("R4 count after 40 events", rv, 32'd110);
        // R2: disable holds the count
        wr(5'h00, 32'h00);
        rd(5'h10, rv); chk("R2 held at disable", rv, 32'd110);
        wait_n(30);
        rd(5'h10, rv); chk("R2 still held", rv, 32'd110);
        // R2: resume from held value, 20 events -> 5 increments
        wr(5'h00, 32'h80);
        wait_n(20);
        rd(5'h10, rv); chk("R2 resumed", rv, 32'd115);
        wr(5'h00, 32'h00);

        // R8: periodic status set, interrupt masked
        rd(5'h0C, rv); chk("R8 tick status", rv, 32'h1);
        chk("R8 irq_tick masked", {31'b0, irq_tick}, 32'h0);
        wr(5'h00, 32'h01);
        chk("R8 irq_tick unmasked", {31'b0, irq_tick}, 32'h1);
        // R9: write 0 keeps, write 1 clears
        wr(5'h0C, 32'h0);
        rd(5'h0C, rv); chk("R9 write 0 keeps", rv, 32'h1);
        wr(5'h0C, 32'h1);
        rd(5'h0C, rv); chk("R9 write 1 clears", rv, 32'h0);
        chk("R9 irq_tick dropped", {31'b0, irq_tick}, 32'h0);

        // R5: load wins over increment (prescale 0, enabled)
        wr(5'h14, 32'h0);
        wr(5'h00, 32'h80);
        wr(5'h04, 32'd500);
        @(negedge clk);
        rd(5'h10, rv); chk("R5 load over increment", rv, 32'd500);
        @(negedge clk);
        rd(5'h10, rv); chk("R5 counting after load", rv, 32'd501);
        wr(5'h00, 32'h00);
        wr(5'h0C, 32'h3);

        // R6: alarm reached by counting
        wr(5'h08, 32'd203);
        wr(5'h04, 32'd200);
        wr(5'h00, 32'h82);
        wait_n(10);
        rd(5'h0C, rv); chk("R6 alarm status", rv & 32'h2, 32'h2);
        chk("R6 irq_alarm", {31'b0, irq_alarm}, 32'h1);
        chk("R8 irq_tick off with mask 0", {31'b0, irq_tick}, 32'h0);
        wr(5'h00, 32'h02);
        wr(5'h0C, 32'h3);

        // R6: alarm reached by a load into a stopped counter
        wr(5'h04, 32'd203);
        wait_n(2);
        rd(5'h0C, rv); chk("R6 alarm by load", rv, 32'h2);
        // R7: stopped at the alarm value, no re-raise after clear
        wr(5'h0C, 32'h2);
        wait_n(15);
        rd(5'h0C, rv); chk("R7 no re-raise", rv, 32'h0);
        chk("R7 irq_alarm low", {31'b0, irq_alarm}, 32'h0);
        rd(5'h10, rv); chk("R7 count stays", rv, 32'd203);

        // R6: mask gates the output but not the status
        wr(5'h00, 32'h00);
        wr(5'h04, 32'd0);
        wait_n(2);
        wr(5'h04, 32'd203);
        wait_n(2);
        rd(5'h0C, rv); chk("R6 status with mask 0", rv, 32'h2);
        chk("R6 irq_alarm masked", {31'b0, irq_alarm}, 32'h0);
        wr(5'h00, 32'h02);
        chk("R6 irq_alarm after unmask", {31'b0, irq_alarm}, 32'h1);
        wr(5'h0C, 32'h3);

        // R3: external source, prescale 1
        wr(5'h00, 32'h00);
        wr(5'h14, 32'h1);
        wr(5'h04, 32'd0);
        @(negedge clk);
        wr(5'h00, 32'hC0);
        wait_n(20);
        rd(5'h10, rv); chk("R3 bus clock ignored when ext selected", rv, 32'd0);
        for (int k = 0; k < 6; k++) begin
            ext_clk = 1'b1; wait_n(5);
            ext_clk = 1'b0; wait_n(5);
        end
        rd(5'h10, rv); chk("R3 six ext edges -> 3", rv, 32'd3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule